// File: doc/BRIEF.md
# ADC Serial Control Interface

This block is the device-side serial front end of a 10-bit, eight-input sampling converter. A host drives an active-low chip select, a serial clock and a serial data line. The block oversamples all three with its own system clock, which must run several times faster than the serial clock. It finds the start bit and captures a control byte. From that byte it decodes the input selection, the output coding and the power or clock mode. It then runs the acquire and convert phases and returns the result on a serial output line with a separate output enable.

The analog path and the successive-approximation core are outside the block. The raw conversion value arrives on a parallel port as an offset-binary code, and the block reads it when a conversion completes. Two timing schemes are supported. In the first, the host clocks the whole exchange in a 24-clock frame. In the second, the block times the conversion itself, signals completion on a strobe, and then returns the result on the same serial clocks that carry the next control byte.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, dout_oe, dout, strobe, acquire and conv_start are 0, pwr_mode is 00, and chan_sel, single_ended and unipolar are 0.
- R2: With cs_n low, din is sampled on rising sclk edges. The start bit is the first 1 sampled, and zeros before it are ignored. The next seven bits fill, in order, chan_sel[2] down to chan_sel[0], unipolar, single_ended, pwr_mode[1] and pwr_mode[0]. The decoded outputs update after the eighth rising edge of the byte, counting the start bit as the first.
- R3: The pwr_mode codes are 00 full power-down, 01 fast power-down, 10 internal timing and 11 external timing. A byte with code 00 or 01 starts no conversion: conv_start stays low, strobe stays low and no result is loaded.
- R4: acquire goes high after the fifth rising edge of a byte, which is the edge that captures the coding bit, and goes low on the eighth falling edge. In modes 10 and 11, conv_start is a one-cycle pulse issued on that eighth falling edge.
- R5: In mode 11, strobe goes high right after the eighth falling edge and goes low on the ninth. Falling edges 9 to 18 present result bits 9 down to 0, and falling edges 19 to 24 present 0.
- R6: In mode 10, strobe stays low while the internal conversion runs, for about CONV_CYCLES system clocks after the eighth falling edge, and then goes high. The first falling edge after that presents result bit 9 and clears strobe. Bits 8 to 0 follow on the next falling edges, then six zeros.
- R7: In mode 10, a new control byte can be clocked in on the same serial clocks that shift out the previous result, and it is decoded and acted on normally.
- R8: With unipolar set, the output code equals res_in. With unipolar clear, the output code is res_in with bit 9 inverted, which gives two's complement. The coding bit is taken from the byte that started the conversion.
- R9: dout_oe is low while cs_n is high, and dout then reads 0. While cs_n stays low, dout changes only in response to a falling sclk edge.
- R10: Raising cs_n at any point ends the transaction. acquire and strobe go low, a running conversion is cancelled with no result loaded, and the next byte after cs_n falls is searched for from its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising sclk |
| res_in | input | 10 | Raw offset-binary conversion value |
| dout | output | 1 | Serial result data, updated on falling sclk |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |
| strobe | output | 1 | Conversion-complete strobe |
| acquire | output | 1 | Sample phase active |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| chan_sel | output | 3 | Decoded input-mux select |
| single_ended | output | 1 | 1 = input against common, 0 = differential pair |
| unipolar | output | 1 | 1 = straight binary, 0 = two's complement |
| pwr_mode | output | 2 | Current power and timing mode |

## Verification
The bench puts idle zeros before the start bit. A design that treats the first sampled bit as the start bit would decode a shifted byte with the wrong channel and mode. It sends power-down bytes and checks that no conversion pulse and no result follow, since a design that ignores the mode bits would convert anyway. In internal timing it interleaves the next byte with the outgoing result and times the strobe window, which catches an off-by-one in bit alignment or in the conversion count. It also raises chip select part-way through a byte and during a conversion. A design that does not abort cleanly would leave acquire or strobe high, finish a stale byte, or shift out a cancelled result.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [1:0] {
    PM_FULL_PD = 2'b00,
    PM_FAST_PD = 2'b01,
    PM_INT_CLK = 2'b10,
    PM_EXT_CLK = 2'b11
  } pwr_mode_e;

  // Field order follows the serial order after the start bit.
  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single;
    pwr_mode_e  mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t) + 1;

endpackage

// File: rtl/sif_edge_det.sv
module sif_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sif_ctrl_rx.sv
module sif_ctrl_rx
  import adc_sif_pkg::*;
#(
  parameter int ACQ_BIT = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_n,
  input  logic  din,
  input  logic  rise,
  input  logic  fall,
  output ctrl_t ctrl,
  output logic  acquire,
  output logic  conv_start
);
  localparam int CW = $clog2(CTRL_W + 1);

  logic [CW-1:0]     cnt;
  logic [CTRL_W-3:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      sh         <= '0;
      ctrl       <= '0;
      acquire    <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (cs_n) begin
        cnt     <= '0;
        acquire <= 1'b0;
      end else if (rise && cnt == '0) begin
        if (din) cnt <= CW'(1);
      end else if (rise && cnt < CW'(CTRL_W)) begin
        sh  <= {sh[CTRL_W-4:0], din};
        cnt <= cnt + CW'(1);
        if (cnt + CW'(1) == CW'(ACQ_BIT)) acquire <= 1'b1;
        if (cnt == CW'(CTRL_W - 1))       ctrl    <= ctrl_t'({sh, din});
      end else if (fall && cnt == CW'(CTRL_W)) begin
        cnt        <= '0;
        acquire    <= 1'b0;
        conv_start <= ctrl.mode[1];
      end
    end
  end
endmodule

// File: rtl/sif_conv_timer.sv
module sif_conv_timer #(
  parameter int CONV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic conv_start,
  input  logic ext_mode,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      tcnt <= '0;
    end else begin
      done <= 1'b0;
      if (conv_start) begin
        if (ext_mode) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          tcnt <= TW'(CONV_CYCLES - 1);
        end
      end else if (busy) begin
        if (tcnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          tcnt <= tcnt - TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sif_out_shift.sv
module sif_out_shift #(
  parameter int RES_W    = 10,
  parameter int OUT_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             conv_start,
  input  logic             unipolar,
  input  logic             done,
  input  logic [RES_W-1:0] res_in,
  output logic             dout,
  output logic             dout_oe,
  output logic             strobe
);
  localparam int PAD = OUT_BITS - RES_W;

  logic                uni_lat;
  logic [OUT_BITS-1:0] sr;
  logic [RES_W-1:0]    code;

  assign code = uni_lat ? res_in : {~res_in[RES_W-1], res_in[RES_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      uni_lat <= 1'b1;
      sr      <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      dout_oe <= ~cs_n;
      if (cs_n) begin
        sr     <= '0;
        dout   <= 1'b0;
        strobe <= 1'b0;
      end else begin
        if (conv_start) uni_lat <= unipolar;
        if (done) begin
          sr     <= {code, {PAD{1'b0}}};
          strobe <= 1'b1;
        end else if (fall) begin
          dout   <= sr[OUT_BITS-1];
          sr     <= sr << 1;
          strobe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_sif_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int OUT_BITS    = 16,
  parameter int CONV_CYCLES = 64,
  parameter int ACQ_BIT     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] res_in,
  output logic             dout,
  output logic             dout_oe,
  output logic             strobe,
  output logic             acquire,
  output logic             conv_start,
  output logic [2:0]       chan_sel,
  output logic             single_ended,
  output logic             unipolar,
  output logic [1:0]       pwr_mode
);
  logic  sclk_rise, sclk_fall;
  logic  conv_busy, conv_done;
  ctrl_t ctrl;

  sif_edge_det u_edge (
    .clk(clk), .rst(rst), .sclk(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  sif_ctrl_rx #(.ACQ_BIT(ACQ_BIT)) u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .din(din),
    .rise(sclk_rise), .fall(sclk_fall),
    .ctrl(ctrl), .acquire(acquire), .conv_start(conv_start)
  );

  sif_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_start(conv_start),
    .ext_mode(ctrl.mode == PM_EXT_CLK),
    .busy(conv_busy), .done(conv_done)
  );

  sif_out_shift #(.RES_W(RES_W), .OUT_BITS(OUT_BITS)) u_out (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fall(sclk_fall),
    .conv_start(conv_start), .unipolar(ctrl.unipolar), .done(conv_done),
    .res_in(res_in), .dout(dout), .dout_oe(dout_oe), .strobe(strobe)
  );

  assign chan_sel     = ctrl.chan;
  assign single_ended = ctrl.single;
  assign unipolar     = ctrl.unipolar;
  assign pwr_mode     = ctrl.mode;
endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk_fall,
  input logic       conv_busy,
  input logic       dout,
  input logic       dout_oe,
  input logic       strobe,
  input logic       acquire,
  input logic       conv_start,
  input logic [1:0] pwr_mode
);
  AST_CS_CLEARS_ACQ: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !acquire); // R10

  AST_CS_CLEARS_STROBE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !strobe); // R10

  AST_CS_RELEASES_DOUT: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_oe && !dout)); // R9

  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && !$stable(dout)) |-> $past(sclk_fall)); // R9

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R4

  AST_START_CONV_MODE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> pwr_mode[1]); // R3

  AST_BUSY_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
    conv_busy |-> !strobe); // R6
endmodule

bind adc_serial_if adc_serial_if_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_fall(sclk_fall),
  .conv_busy(conv_busy), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
  .acquire(acquire), .conv_start(conv_start), .pwr_mode(pwr_mode)
);

// File: tb/tb_adc_serial_if.sv
module tb_adc_serial_if;
  localparam int CONV = 40;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [9:0] res_in = '0;
  logic dout, dout_oe, strobe, acquire, conv_start;
  logic [2:0] chan_sel;
  logic single_ended, unipolar;
  logic [1:0] pwr_mode;

  always #10 clk = ~clk;

  adc_serial_if #(.CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .res_in(res_in),
    .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .acquire(acquire),
    .conv_start(conv_start), .chan_sel(chan_sel), .single_ended(single_ended),
    .unipolar(unipolar), .pwr_mode(pwr_mode)
  );

  int errs = 0, checks = 0;
  int nstart = 0, e_nstart = 0;
  int bitn = 0;
  logic [7:0] byte_m = '0;
  bit q[$];
  logic e_dout = 0, e_oe = 0, e_strobe = 0, e_acq = 0;
  logic [2:0] e_chan = 0;
  logic e_uni = 0, e_se = 0, conv_uni = 1;
  logic [1:0] e_mode = 0;

  always @(posedge clk) if (!rst && conv_start) nstart <= nstart + 1;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    check(tag, "dout_oe", int'(dout_oe), int'(e_oe));
    check(tag, "dout", int'(dout), int'(e_dout));
    check(tag, "strobe", int'(strobe), int'(e_strobe));
    check(tag, "acquire", int'(acquire), int'(e_acq));
    check(tag, "chan_sel", int'(chan_sel), int'(e_chan));
    check(tag, "unipolar", int'(unipolar), int'(e_uni));
    check(tag, "single_ended", int'(single_ended), int'(e_se));
    check(tag, "pwr_mode", int'(pwr_mode), int'(e_mode));
  endtask

  task automatic load_result();
    logic [9:0] code;
    code = conv_uni ? res_in : {~res_in[9], res_in[8:0]};
    q.delete();
    for (int i = 9; i >= 0; i--) q.push_back(code[i]);
    for (int i = 0; i < 6; i++) q.push_back(1'b0);
    e_strobe = 1'b1;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(logic b, string tag);
    din = b; sclk = 1'b1;
    if (bitn == 0) begin
      if (b) bitn = 1;
    end else if (bitn < 8) begin
      byte_m = {byte_m[6:0], b};
      bitn++;
      if (bitn == 5) e_acq = 1'b1;
      if (bitn == 8) begin
        e_chan = byte_m[6:4]; e_uni = byte_m[3];
        e_se = byte_m[2]; e_mode = byte_m[1:0];
      end
    end
    wait_n(HALF); cmp_all(tag);
    sclk = 1'b0;
    e_strobe = 1'b0;
    e_dout = (q.size() > 0) ? q.pop_front() : 1'b0;
    if (bitn == 8) begin
      bitn = 0; e_acq = 1'b0;
      if (e_mode[1]) begin
        e_nstart++;
        conv_uni = e_uni;
        if (e_mode == 2'b11) load_result();
      end
    end
    wait_n(HALF); cmp_all(tag);
  endtask

  task automatic send_byte(logic [7:0] b, string tag);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], tag);
  endtask

  task automatic zeros(int n, string tag);
    for (int i = 0; i < n; i++) clk_bit(1'b0, tag);
  endtask

  task automatic cs_low(string tag);
    cs_n = 1'b0; e_oe = 1'b1; bitn = 0;
    wait_n(4); cmp_all(tag);
  endtask

  task automatic cs_high(string tag);
    cs_n = 1'b1; e_oe = 1'b0; e_dout = 1'b0; e_strobe = 1'b0; e_acq = 1'b0;
    bitn = 0; q.delete();
    wait_n(4); cmp_all(tag);
  endtask

  // internal-timing wait; count starts at HALF since clk_bit already waited
  task automatic wait_conv(string tag);
    int n = HALF;
    while (!strobe && n < CONV + 30) begin @(negedge clk); n++; end
    check(tag, "conversion time in window", int'(n >= CONV - 1 && n <= CONV + 5), 1);
    load_result();
    wait_n(2); cmp_all(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    wait_n(5);
    check("R1", "conv_start", int'(conv_start), 0);
    cmp_all("R1");
    rst = 1'b0;
    wait_n(2); cmp_all("R1");

    // external frame with idle zeros before the start bit
    res_in = 10'h2A5;
    cs_low("R9");
    zeros(3, "R2");
    send_byte(8'hDF, "R2");
    check("R4", "conv_start pulses", nstart, e_nstart);
    zeros(16, "R5");
    cs_high("R9");

    // external, bipolar coding
    res_in = 10'h155;
    cs_low("R8");
    send_byte(8'hA3, "R8");
    zeros(16, "R8");
    cs_high("R8");
    check("R8", "conv_start pulses", nstart, e_nstart);

    // power-down bytes: no conversion
    cs_low("R3");
    send_byte(8'hE8, "R3");
    zeros(4, "R3");
    send_byte(8'h95, "R3");
    zeros(4, "R3");
    check("R3", "no conv_start in power-down", nstart, e_nstart);
    cs_high("R3");

    // internal timing with interleaved next byte
    res_in = 10'h0F0;
    cs_low("R6");
    send_byte(8'hBA, "R6");
    wait_conv("R6");
    res_in = 10'h30C;
    send_byte(8'hC6, "R7");
    wait_conv("R7");
    zeros(16, "R6");
    check("R7", "conv_start pulses", nstart, e_nstart);
    cs_high("R6");

    // abort part-way through a byte
    cs_low("R10");
    clk_bit(1, "R10"); clk_bit(0, "R10"); clk_bit(1, "R10");
    cs_high("R10");
    cs_low("R10");
    for (int i = 0; i < 5; i++) clk_bit(1, "R10");
    cs_high("R10");
    res_in = 10'h001;
    cs_low("R10");
    send_byte(8'hF3, "R10");
    zeros(16, "R10");
    cs_high("R10");

    // abort during an internal conversion
    res_in = 10'h3AA;
    cs_low("R10");
    send_byte(8'h8A, "R10");
    cs_high("R10");
    wait_n(CONV + 10); cmp_all("R10");
    cs_low("R10");
    zeros(8, "R10");
    cs_high("R10");
    check("R10", "conv_start pulses", nstart, e_nstart);

    summary();
    $finish;
  end
endmodule